// File: doc/BRIEF.md
# Subsystem Identification Register Pair with Guarded Reset

This block holds a 32-bit identification doubleword made of two 16-bit halves: a subsystem vendor code in the low half and a subsystem code in the high half. Configuration software reads the doubleword at offset 40h. It may write the doubleword only after it clears a protection bit, bit 5 of the control word at offset 80h. Software is expected to set that bit again afterwards, which makes the pair read-only once more. After power-up, an external serial-memory loader can preset the pair through a load port. The block only flags that such a memory is present and asks for the load. It does not run the serial protocol itself.

There are two active-low resets: a global reset and a bus reset. While suspend is low, either reset clears the pair to zero and sets the protection bit to 1. While suspend is high, neither reset touches any stored state, including the loader sequence. The output-enable flag is held low during either reset and while suspend is high.

The loader sequence is a four-state machine:
- `LD_IDLE` moves to `LD_ARMED` in the first clock after global reset is released, provided both power-switch control lines read high and suspend is low. That same clock also sets `ee_present`.
- `LD_ARMED` moves to `LD_FETCH` once the bus reset is high.
- `LD_FETCH` raises `ld_req` and moves to `LD_DONE` when `ld_valid` arrives. The load data then replaces the pair.
- `LD_DONE` holds.

An unsuspended bus reset sends the machine back to `LD_ARMED` if a memory is present, and to `LD_IDLE` otherwise. An unsuspended global reset sends it to `LD_IDLE`.

A power-up timer counts clocks while global reset is held low. It raises `rel_ok` once `PWRUP_CYCLES` clocks have passed (3300 clocks is 100 µs at 33 MHz).

Top module: `subsys_id_regs`

## Requirements
- R1: An unsuspended global or bus reset, when sampled, makes offset 40h read 0 and offset 80h read 20h (protection bit 5 set, all other bits 0).
- R2: While the protection bit is 1, a write to offset 40h leaves the pair unchanged.
- R3: While the protection bit is 0, a write to offset 40h updates each byte whose enable is set. Enable bit k covers data bits 8k+7..8k, and bits 15..0 are the vendor code. A write to offset 80h with byte enable 0 set loads data bit 5 into the protection bit.
- R4: While suspend is high, asserting either reset leaves the pair and the protection bit unchanged.
- R5: `out_en` is 0 whenever `grst_n` is 0, `brst_n` is 0 or `suspend` is 1, and is 1 otherwise.
- R6: In the first clock with `grst_n` high after it was low, with suspend low, `ee_present` takes the AND of both `vcc_ctl` bits. An unsuspended global reset clears it.
- R7: With `ee_present` set, the clock edge that samples `brst_n` high moves the loader from armed to fetch, and `ld_req` goes to 1.
- R8: `ld_valid` while `ld_req` is 1 copies `ld_data` into the pair and drops `ld_req` at the same edge. `ld_valid` at any other time is ignored.
- R9: When a load and an unlocked software write to offset 40h fall in the same cycle, the load value is kept.
- R10: An unsuspended bus reset with `ee_present` set keeps `ee_present` and re-arms the loader, so `ld_req` returns after the bus reset is released.
- R11: `rel_ok` is 0 until `grst_n` has been sampled low on `PWRUP_CYCLES` consecutive edges, is 1 from then on while `grst_n` stays low, and is 0 after an edge with `grst_n` high.
- R12: Reads of any offset other than 40h and 80h return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| grst_n | input | 1 | Global reset, active low |
| brst_n | input | 1 | Bus reset, active low |
| suspend | input | 1 | Shields stored state from both resets |
| vcc_ctl | input | 2 | Power-switch control lines sampled for memory presence |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration byte offset (doubleword aligned) |
| cfg_be | input | 2*ID_W/8 | Write byte enables |
| cfg_wdata | input | 2*ID_W | Write data |
| cfg_rdata | output | 2*ID_W | Read data for `cfg_addr` |
| ld_valid | input | 1 | Loader presents a value |
| ld_data | input | 2*ID_W | Loader value for the pair |
| ld_req | output | 1 | Block is waiting for the loader value |
| ee_present | output | 1 | Serial memory detected at global reset release |
| out_en | output | 1 | Output drivers may be enabled |
| rel_ok | output | 1 | Global reset has been held long enough to release |

## Verification
The hardest case to reach is a reset that arrives while suspend is high and the pair holds a software-written value. To get there, the stimulus first clears the protection bit, writes a known value and raises suspend. It then asserts the bus reset, adds the global reset, and releases both in turn before it drops suspend. It checks the pair and the protection bit at each step. A second hard case is a load and an unlocked software write in the same clock. This only arises in the fetch state, so the bench first unlocks the pair while the loader waits and then drives both strobes on one edge.

// File: rtl/subsys_id_pkg.sv
package subsys_id_pkg;
    typedef enum logic [1:0] {
        LD_IDLE  = 2'd0,
        LD_ARMED = 2'd1,
        LD_FETCH = 2'd2,
        LD_DONE  = 2'd3
    } ld_state_e;

    localparam logic [7:0] OFS_IDPAIR = 8'h40;
    localparam logic [7:0] OFS_SYSCTL = 8'h80;
    localparam int         LOCK_POS   = 5;
endpackage

// File: rtl/subsys_rst_gate.sv
module subsys_rst_gate #(
    parameter int PWRUP_CYCLES = 3300
) (
    input  logic clk,
    input  logic grst_n,
    input  logic brst_n,
    input  logic suspend,
    output logic g_clr,
    output logic b_clr,
    output logic grst_rise,
    output logic out_en,
    output logic rel_ok
);
    localparam int CNT_W = $clog2(PWRUP_CYCLES + 1);

    logic             grst_q;
    logic [CNT_W-1:0] hold_cnt;

    // previous level of global reset, used for release detection
    always_ff @(posedge clk) begin
        grst_q <= grst_n;
    end

    // clocks spent with global reset low, saturating
    always_ff @(posedge clk) begin
        if (grst_n) begin
            hold_cnt <= '0;
        end else if (hold_cnt != CNT_W'(PWRUP_CYCLES)) begin
            hold_cnt <= hold_cnt + 1'b1;
        end
    end

    always_comb begin
        g_clr     = !grst_n && !suspend;
        b_clr     = grst_n && !brst_n && !suspend;
        grst_rise = grst_n && !grst_q;
        out_en    = grst_n && brst_n && !suspend;
        rel_ok    = (hold_cnt == CNT_W'(PWRUP_CYCLES));
    end
endmodule

// File: rtl/subsys_ld_fsm.sv
module subsys_ld_fsm
    import subsys_id_pkg::*;
(
    input  logic       clk,
    input  logic       g_clr,
    input  logic       b_clr,
    input  logic       grst_rise,
    input  logic       suspend,
    input  logic       brst_n,
    input  logic [1:0] vcc_ctl,
    input  logic       ld_valid,
    output logic       ee_present,
    output logic       ld_req,
    output logic       ld_load
);
    ld_state_e state_q;
    ld_state_e state_nx;
    logic      arm_now;

    assign arm_now = grst_rise && !suspend && (&vcc_ctl);

    // presence flag
    always_ff @(posedge clk) begin
        if (g_clr) begin
            ee_present <= 1'b0;
        end else if (grst_rise && !suspend) begin
            ee_present <= &vcc_ctl;
        end
    end

    // next state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            LD_IDLE:  if (arm_now)  state_nx = LD_ARMED;
            LD_ARMED: if (brst_n)   state_nx = LD_FETCH;
            LD_FETCH: if (ld_valid) state_nx = LD_DONE;
            LD_DONE:  state_nx = LD_DONE;
            default:  state_nx = LD_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (g_clr) begin
            state_q <= LD_IDLE;
        end else if (b_clr) begin
            state_q <= (ee_present || arm_now) ? LD_ARMED : LD_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // outputs
    always_comb begin
        ld_req  = 1'b0;
        unique case (state_q)
            LD_FETCH: ld_req = 1'b1;
            default:  ld_req = 1'b0;
        endcase
        ld_load = ld_req && ld_valid;
    end
endmodule

// File: rtl/subsys_id_store.sv
module subsys_id_store
    import subsys_id_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int ID_W   = 16
) (
    input  logic                  clk,
    input  logic                  clr,
    input  logic                  cfg_wr,
    input  logic [ADDR_W-1:0]     cfg_addr,
    input  logic [2*ID_W/8-1:0]   cfg_be,
    input  logic [2*ID_W-1:0]     cfg_wdata,
    input  logic                  ld_load,
    input  logic [2*ID_W-1:0]     ld_data,
    output logic [2*ID_W-1:0]     cfg_rdata,
    output logic [2*ID_W-1:0]     id_pair,
    output logic                  lock_q
);
    localparam int DATA_W  = 2 * ID_W;
    localparam int NB      = DATA_W / 8;
    localparam int LOCK_BE = LOCK_POS / 8;

    logic hit_id;
    logic hit_ctl;
    logic sw_wr;

    assign hit_id  = (cfg_addr == ADDR_W'(OFS_IDPAIR));
    assign hit_ctl = (cfg_addr == ADDR_W'(OFS_SYSCTL));
    assign sw_wr   = cfg_wr && hit_id && !lock_q;

    for (genvar b = 0; b < NB; b++) begin : g_byte
        logic [7:0] q;
        always_ff @(posedge clk) begin
            if (clr) begin
                q <= '0;
            end else if (ld_load) begin
                q <= ld_data[b*8 +: 8];
            end else if (sw_wr && cfg_be[b]) begin
                q <= cfg_wdata[b*8 +: 8];
            end
        end
        assign id_pair[b*8 +: 8] = q;
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            lock_q <= 1'b1;
        end else if (cfg_wr && hit_ctl && cfg_be[LOCK_BE]) begin
            lock_q <= cfg_wdata[LOCK_POS];
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (hit_id) begin
            cfg_rdata = id_pair;
        end else if (hit_ctl) begin
            cfg_rdata[LOCK_POS] = lock_q;
        end
    end
endmodule

// File: rtl/subsys_id_regs.sv
module subsys_id_regs #(
    parameter int ADDR_W       = 8,
    parameter int ID_W         = 16,
    parameter int PWRUP_CYCLES = 3300
) (
    input  logic                 clk,
    input  logic                 grst_n,
    input  logic                 brst_n,
    input  logic                 suspend,
    input  logic [1:0]           vcc_ctl,
    input  logic                 cfg_wr,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [2*ID_W/8-1:0]  cfg_be,
    input  logic [2*ID_W-1:0]    cfg_wdata,
    output logic [2*ID_W-1:0]    cfg_rdata,
    input  logic                 ld_valid,
    input  logic [2*ID_W-1:0]    ld_data,
    output logic                 ld_req,
    output logic                 ee_present,
    output logic                 out_en,
    output logic                 rel_ok
);
    logic              g_clr;
    logic              b_clr;
    logic              grst_rise;
    logic              ld_load;
    logic [2*ID_W-1:0] id_pair;
    logic              lock_q;

    subsys_rst_gate #(.PWRUP_CYCLES(PWRUP_CYCLES)) u_gate (
        .clk       (clk),
        .grst_n    (grst_n),
        .brst_n    (brst_n),
        .suspend   (suspend),
        .g_clr     (g_clr),
        .b_clr     (b_clr),
        .grst_rise (grst_rise),
        .out_en    (out_en),
        .rel_ok    (rel_ok)
    );

    subsys_ld_fsm u_fsm (
        .clk        (clk),
        .g_clr      (g_clr),
        .b_clr      (b_clr),
        .grst_rise  (grst_rise),
        .suspend    (suspend),
        .brst_n     (brst_n),
        .vcc_ctl    (vcc_ctl),
        .ld_valid   (ld_valid),
        .ee_present (ee_present),
        .ld_req     (ld_req),
        .ld_load    (ld_load)
    );

    subsys_id_store #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_store (
        .clk       (clk),
        .clr       (g_clr || b_clr),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_be    (cfg_be),
        .cfg_wdata (cfg_wdata),
        .ld_load   (ld_load),
        .ld_data   (ld_data),
        .cfg_rdata (cfg_rdata),
        .id_pair   (id_pair),
        .lock_q    (lock_q)
    );
endmodule

// File: rtl/subsys_id_chk.sv
module subsys_id_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              grst_n,
    input logic              brst_n,
    input logic              suspend,
    input logic              out_en,
    input logic              ld_req,
    input logic              ld_valid,
    input logic [DATA_W-1:0] ld_data,
    input logic              ee_present,
    input logic [DATA_W-1:0] id_pair,
    input logic              lock_q
);
    AST_LOCK_HOLDS_ID: assert property (@(posedge clk) disable iff (!grst_n || !brst_n)
        (lock_q && !ld_req) |=> $stable(id_pair)); // R2

    AST_SUSPEND_SHIELDS: assert property (@(posedge clk) disable iff (!suspend)
        ((!grst_n || !brst_n) && !ld_req) |=> ($stable(id_pair) && $stable(lock_q))); // R4

    AST_OE_OFF_BUS_RESET: assert property (@(posedge clk) disable iff (!grst_n)
        (!brst_n || suspend) |-> !out_en); // R5

    AST_REQ_NEEDS_PRESENT: assert property (@(posedge clk) disable iff (!grst_n || !brst_n)
        ld_req |-> ee_present); // R7

    AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!grst_n || !brst_n)
        (ld_req && ld_valid) |=> (id_pair == $past(ld_data) && !ld_req)); // R8
endmodule

bind subsys_id_regs subsys_id_chk #(.DATA_W(2*ID_W)) u_chk (
    .clk        (clk),
    .grst_n     (grst_n),
    .brst_n     (brst_n),
    .suspend    (suspend),
    .out_en     (out_en),
    .ld_req     (ld_req),
    .ld_valid   (ld_valid),
    .ld_data    (ld_data),
    .ee_present (ee_present),
    .id_pair    (id_pair),
    .lock_q     (lock_q)
);

// File: tb/sim_subsys_id_regs.sv
module sim_subsys_id_regs;
    localparam int PWR = 3300;

    logic        clk = 1'b0;
    logic        grst_n, brst_n, suspend, cfg_wr, ld_valid;
    logic [1:0]  vcc_ctl;
    logic [7:0]  cfg_addr;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata, ld_data, cfg_rdata;
    logic        ld_req, ee_present, out_en, rel_ok;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_id;
    logic        exp_lock;

    always #5 clk = ~clk;

    subsys_id_regs u0 (
        .clk(clk), .grst_n(grst_n), .brst_n(brst_n), .suspend(suspend),
        .vcc_ctl(vcc_ctl), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ld_valid(ld_valid),
        .ld_data(ld_data), .ld_req(ld_req), .ee_present(ee_present),
        .out_en(out_en), .rel_ok(rel_ok)
    );

    function automatic logic [31:0] merge_be(logic [31:0] old, logic [31:0] nw, logic [3:0] be);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = nw[b*8 +: 8];
        return r;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
        cfg_addr = a;
        #1;
        chk(req, cfg_rdata, exp);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d, logic [3:0] be);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_be = be;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #1_500_000;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        grst_n = 1; brst_n = 0; suspend = 0; vcc_ctl = 2'b00;
        cfg_wr = 0; cfg_addr = 8'h00; cfg_be = 4'h0; cfg_wdata = '0;
        ld_valid = 0; ld_data = '0;
        repeat (3) @(negedge clk);
        rd_chk("R1 id after bus reset", 8'h40, 32'h0);
        rd_chk("R1 ctl after bus reset", 8'h80, 32'h20);
        chk("R5 oe in bus reset", {31'b0, out_en}, 32'd0);

        // global reset held: power-up timer
        grst_n = 0;
        repeat (PWR - 1) @(posedge clk);
        @(negedge clk);
        chk("R11 rel_ok early", {31'b0, rel_ok}, 32'd0);
        @(negedge clk);
        chk("R11 rel_ok at limit", {31'b0, rel_ok}, 32'd1);
        chk("R5 oe in global reset", {31'b0, out_en}, 32'd0);

        // release global reset with memory present
        vcc_ctl = 2'b11; grst_n = 1;
        @(negedge clk);
        chk("R6 presence", {31'b0, ee_present}, 32'd1);
        chk("R11 rel_ok after release", {31'b0, rel_ok}, 32'd0);
        chk("R7 no req in bus reset", {31'b0, ld_req}, 32'd0);
        brst_n = 1;
        @(negedge clk);
        chk("R7 req after bus release", {31'b0, ld_req}, 32'd1);
        chk("R5 oe active", {31'b0, out_en}, 32'd1);

        // unlock, then load and write together
        wr(8'h80, 32'h0, 4'h1);
        rd_chk("R3 unlock", 8'h80, 32'h0);
        cfg_wr = 1; cfg_addr = 8'h40; cfg_wdata = 32'hBBBB_2222; cfg_be = 4'hF;
        ld_valid = 1; ld_data = 32'h1234_ABCD;
        @(negedge clk);
        cfg_wr = 0; ld_valid = 0;
        rd_chk("R9 load wins", 8'h40, 32'h1234_ABCD);
        chk("R8 req drops", {31'b0, ld_req}, 32'd0);
        ld_valid = 1; ld_data = 32'hDEAD_BEEF;
        @(negedge clk);
        ld_valid = 0;
        rd_chk("R8 late load ignored", 8'h40, 32'h1234_ABCD);

        // random software traffic
        exp_id = 32'h1234_ABCD; exp_lock = 0;
        for (int i = 0; i < 200; i++) begin
            logic [31:0] d  = $urandom;
            logic [3:0]  be = 4'($urandom);
            logic [7:0]  oa = {6'($urandom), 2'b00};
            if ($urandom_range(0, 2) == 0) begin
                logic lk = 1'($urandom);
                wr(8'h80, {26'b0, lk, 5'b0}, 4'h1);
                exp_lock = lk;
            end
            wr(8'h40, d, be);
            if (!exp_lock) exp_id = merge_be(exp_id, d, be);
            rd_chk(exp_lock ? "R2 locked write" : "R3 byte write", 8'h40, exp_id);
            rd_chk("R3 lock readback", 8'h80, {26'b0, exp_lock, 5'b0});
            if (oa != 8'h40 && oa != 8'h80) rd_chk("R12 other offset", oa, 32'h0);
        end

        // bus reset re-arms the loader
        @(negedge clk);
        brst_n = 0;
        @(negedge clk);
        rd_chk("R1 id cleared", 8'h40, 32'h0);
        rd_chk("R1 lock set", 8'h80, 32'h20);
        chk("R10 presence kept", {31'b0, ee_present}, 32'd1);
        brst_n = 1;
        @(negedge clk);
        chk("R10 req again", {31'b0, ld_req}, 32'd1);
        ld_valid = 1; ld_data = 32'h5A5A_0F0F;
        @(negedge clk);
        ld_valid = 0;
        rd_chk("R10 reload", 8'h40, 32'h5A5A_0F0F);

        // suspend shields state
        wr(8'h80, 32'h0, 4'h1);
        wr(8'h40, 32'hCAFE_F00D, 4'hF);
        @(negedge clk);
        suspend = 1;
        #1;
        chk("R5 oe in suspend", {31'b0, out_en}, 32'd0);
        brst_n = 0;
        repeat (3) @(negedge clk);
        rd_chk("R4 bus reset shielded", 8'h40, 32'hCAFE_F00D);
        grst_n = 0;
        repeat (3) @(negedge clk);
        rd_chk("R4 global reset shielded", 8'h40, 32'hCAFE_F00D);
        rd_chk("R4 lock shielded", 8'h80, 32'h0);
        grst_n = 1;
        @(negedge clk);
        brst_n = 1;
        @(negedge clk);
        suspend = 0;
        @(negedge clk);
        rd_chk("R4 after suspend", 8'h40, 32'hCAFE_F00D);
        chk("R6 presence kept in suspend", {31'b0, ee_present}, 32'd1);

        // global reset without memory
        vcc_ctl = 2'b01; grst_n = 0;
        @(negedge clk);
        chk("R6 cleared by global reset", {31'b0, ee_present}, 32'd0);
        rd_chk("R1 global clear", 8'h40, 32'h0);
        grst_n = 1;
        repeat (2) @(negedge clk);
        chk("R6 absent", {31'b0, ee_present}, 32'd0);
        chk("R7 no req without memory", {31'b0, ld_req}, 32'd0);
        ld_valid = 1; ld_data = 32'h7777_7777;
        @(negedge clk);
        ld_valid = 0;
        rd_chk("R8 load ignored idle", 8'h40, 32'h0);

        finish_run();
    end
endmodule